// File: doc/BRIEF.md
# SPI Master Serial Shift Engine

This block is the serial half of an SPI master. It pulls words from the read port of a transmit FIFO, shifts each one out MSB first on the data-out line while it samples the data-in line, and writes the received words to the write port of a receive FIFO. It makes the serial clock from a programmable even divider of the system clock. It also drives a one-hot, active-low slave-select bus by itself, so software never toggles the select line.

A 10-bit control word sets the frame length, the clock polarity and phase, and the transfer direction. A burst starts as soon as the transmit FIFO holds a word and the divider is usable. The select line stays low for as long as frames follow each other. It is released half a serial-clock period after the last frame. In receive-only mode a single word in the transmit FIFO serves as the trigger. The engine then shifts out zeros for a programmed number of frames. The frame-format field is decoded but has no effect: every format runs as plain SPI.

Top module: `spi_shift_engine`

## Requirements
- R1: The control word `cfg_ctrl` is split as follows. Bits [3:0] hold the frame length minus one (1 to 16 bits). Bits [5:4] hold the frame format, which is ignored: every value behaves as SPI. Bit 6 is the clock phase and bit 7 is the clock polarity. Bits [9:8] hold the direction: 0 is full duplex, 1 is transmit only, 2 is receive only, and 3 behaves as full duplex.
- R2: Each frame puts the low N bits of the transmit word on `mosi`, most significant bit first.
- R3: While idle, `sclk` rests at the polarity bit. With phase 0, `mosi` is valid before the first edge, and `miso` is sampled on leading edges. With phase 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges. The pushed word equals the N bits the slave returned.
- R4: The `sclk` period is `cfg_div` with bit 0 cleared, counted in system clocks. Bit 0 of `cfg_div` has no effect.
- R5: A divider value below 2 (0 or 1) starts no burst. No word is popped, `busy` stays low, and every `ss_n` line stays high.
- R6: A burst starts when `tx_empty` is low. `tx_pop` pulses once per frame, and only while `tx_empty` is low. Only the `ss_n` line picked by `cfg_target` goes low. It falls exactly once per burst and stays low across back-to-back frames.
- R7: `ss_n` is released half an `sclk` period (divider/2 system clocks) after the last `sclk` edge. `busy` falls together with the release, and the transmit FIFO is then empty.
- R8: In transmit-only mode `rx_push` never pulses.
- R9: In receive-only mode one trigger word is popped. The engine shifts out zeros for `cfg_rx_frames`+1 frames and pushes each received frame.
- R10: A frame that completes while `rx_full` is high is dropped and `rx_push` stays low.
- R11: After reset `busy`, `tx_pop` and `rx_push` are low, every `ss_n` line is high, and `sclk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 10 | Control word (frame length, format, phase, polarity, direction) |
| cfg_rx_frames | input | FRM_W | Receive-only frame count minus one |
| cfg_div | input | DIV_W | Serial clock divider (even, at least 2) |
| cfg_target | input | SEL_W | Index of the slave-select line to drive |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | DW | Transmit FIFO head word (first-word fall-through) |
| tx_pop | output | 1 | Transmit FIFO read strobe |
| rx_full | input | 1 | Receive FIFO full |
| rx_push | output | 1 | Receive FIFO write strobe |
| rx_data | output | DW | Received word, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low one-hot slave selects |
| busy | output | 1 | Burst in progress |

## Verification
At the last edge of a frame, three things can happen in one system cycle. The final `miso` bit is sampled, the finished word is pushed, and the next transmit word is popped and loaded. With phase 1 the last edge is a sampling edge, so the push has to take the freshly sampled bit even though the shift register is being reloaded. The bench provokes this by sweeping all four clock modes with three-frame bursts at the fastest divider, where the edges and the load sit back to back. It judges the result by comparing every received word with the slave's word and every captured `mosi` frame with the transmit word.

// File: rtl/spi_eng_pkg.sv
// Shared types of the SPI shift engine.
// Assumes the control word layout is fixed at 10 bits.
package spi_eng_pkg;
    localparam int CTRL_W = 10;

    typedef enum logic [1:0] {
        XM_DUPLEX  = 2'd0,
        XM_TX_ONLY = 2'd1,
        XM_RX_ONLY = 2'd2,
        XM_EEPROM  = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic [1:0] mode;
        logic       cpol;
        logic       cpha;
        logic [1:0] frf;
        logic [3:0] fsz_m1;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/spi_clk_div.sv
// Half-period tick generator: while run is high, tick pulses once every
// `half` system clocks. Restart reloads the count so the first tick comes
// `half` clocks later. Assumes half >= 1 whenever run is high.
module spi_clk_div #(
    parameter int HALF_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);
    logic [HALF_W-1:0] cnt_q;

    assign tick = run && !restart && (cnt_q == '0);

    // Down-counter that reloads after each tick or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= half - 1'b1;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? half - 1'b1 : cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/spi_frame_shifter.sv
// Transmit and receive shift registers of one frame. The transmit word is
// shifted left, and mosi shows bit fsz_m1, so data leaves MSB first. The
// receive register fills from the LSB. rx_next already holds a sample
// taken in this cycle. Assumes DW >= 16 so any 4-bit fsz_m1 is in range.
module spi_frame_shifter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic          shift_en,
    input  logic          sample_en,
    input  logic [3:0]    fsz_m1,
    input  logic          miso,
    output logic          mosi,
    output logic [DW-1:0] rx_next
);
    logic [DW-1:0] tx_sr_q;
    logic [DW-1:0] rx_sr_q;
    logic [DW-1:0] rx_shifted;

    assign rx_shifted = {rx_sr_q[DW-2:0], miso};
    assign rx_next    = sample_en ? rx_shifted : rx_sr_q;
    assign mosi       = tx_sr_q[fsz_m1];

    // Load a new frame, or shift out and sample in on the chosen edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr_q <= '0;
            rx_sr_q <= '0;
        end else if (load) begin
            tx_sr_q <= load_word;
            rx_sr_q <= '0;
        end else begin
            if (shift_en)  tx_sr_q <= tx_sr_q << 1;
            if (sample_en) rx_sr_q <= rx_shifted;
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
// SPI master serial shift engine: pops words from a first-word
// fall-through TX FIFO, shifts frames on sclk/mosi/miso, pushes received
// frames to an RX FIFO and drives a one-hot slave select per burst.
// Assumes the configuration inputs are stable while busy is high. They
// are latched at burst start anyway.
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int DW     = 16,
    parameter int DIV_W  = 16,
    parameter int FRM_W  = 16,
    parameter int NUM_SS = 4,
    localparam int SEL_W = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [FRM_W-1:0]  cfg_rx_frames,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [SEL_W-1:0]  cfg_target,
    input  logic              tx_empty,
    input  logic [DW-1:0]     tx_data,
    output logic              tx_pop,
    input  logic              rx_full,
    output logic              rx_push,
    output logic [DW-1:0]     rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_SS-1:0] ss_n,
    output logic              busy
);
    localparam int HALF_W = DIV_W - 1;

    eng_state_e        state_q;
    ctrl_t             cfg_in, cfg_q;
    logic [HALF_W-1:0] half_q, half_live, half_use;
    logic [SEL_W-1:0]  sel_q;
    logic [FRM_W-1:0]  frames_left_q;
    logic [4:0]        edge_q;
    logic              sclk_q, ss_act_q;
    logic              div_ok, start, tick, last_edge, more, next_frame;
    logic              rx_only, tx_only, load, shift_en, sample_en;
    xfer_mode_e        live_mode;

    assign cfg_in    = ctrl_t'(cfg_ctrl);
    assign half_live = cfg_div[DIV_W-1:1];
    assign div_ok    = (half_live != '0);
    assign half_use  = (state_q == ST_IDLE) ? half_live : half_q;

    // Direction in force: live while idle, latched during a burst; code 3 runs as duplex.
    always_comb begin
        live_mode = xfer_mode_e'((state_q == ST_IDLE) ? cfg_in.mode : cfg_q.mode);
        if (live_mode == XM_EEPROM) live_mode = XM_DUPLEX;
    end
    assign rx_only = (live_mode == XM_RX_ONLY);
    assign tx_only = (live_mode == XM_TX_ONLY);

    assign start      = (state_q == ST_IDLE) && div_ok && !tx_empty;
    assign last_edge  = (state_q == ST_SHIFT) && tick && (edge_q == {cfg_q.fsz_m1, 1'b1});
    assign more       = rx_only ? (frames_left_q != '0) : !tx_empty;
    assign next_frame = last_edge && more;
    assign load       = start || next_frame;
    assign tx_pop     = start || (next_frame && !rx_only);
    assign rx_push    = last_edge && !tx_only && !rx_full;

    // edge_q even means the coming edge is a leading one.
    assign sample_en = (state_q == ST_SHIFT) && tick && (cfg_q.cpha ? edge_q[0] : !edge_q[0]);
    assign shift_en  = (state_q == ST_SHIFT) && tick &&
                       (cfg_q.cpha ? (!edge_q[0] && edge_q != '0) : edge_q[0]);

    spi_clk_div #(.HALF_W(HALF_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q != ST_IDLE),
        .restart (start),
        .half    (half_use),
        .tick    (tick)
    );

    spi_frame_shifter #(.DW(DW)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (rx_only ? '0 : tx_data),
        .shift_en  (shift_en),
        .sample_en (sample_en),
        .fsz_m1    (start ? cfg_in.fsz_m1 : cfg_q.fsz_m1),
        .miso      (miso),
        .mosi      (mosi),
        .rx_next   (rx_data)
    );

    // Burst sequencer: idle -> shifting frames -> half-period hold -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            cfg_q         <= '0;
            half_q        <= '0;
            sel_q         <= '0;
            frames_left_q <= '0;
            edge_q        <= '0;
            sclk_q        <= 1'b0;
            ss_act_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= cfg_in.cpol;
                    if (start) begin
                        state_q       <= ST_SHIFT;
                        cfg_q         <= cfg_in;
                        half_q        <= half_live;
                        sel_q         <= cfg_target;
                        frames_left_q <= cfg_rx_frames;
                        edge_q        <= '0;
                        ss_act_q      <= 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_q + 1'b1;
                        if (last_edge) begin
                            if (more) begin
                                edge_q <= '0;
                                if (rx_only) frames_left_q <= frames_left_q - 1'b1;
                            end else begin
                                state_q <= ST_HOLD;
                            end
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        state_q  <= ST_IDLE;
                        ss_act_q <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sclk = sclk_q;
    assign busy = (state_q != ST_IDLE);

    // One active-low select line per slave, picked by the latched index.
    for (genvar g = 0; g < NUM_SS; g++) begin : g_ss
        assign ss_n[g] = !(ss_act_q && (sel_q == SEL_W'(g)));
    end

    // R6: a pop only ever happens against a non-empty FIFO.
    assert_pop_needs_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    // R10: never write a full receive FIFO.
    assert_no_push_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_full);
    // R8: a transmit-only burst writes nothing back.
    assert_tx_only_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_q.mode == XM_TX_ONLY) |-> !rx_push);
    // R7: once the burst ends, every select line is released.
    assert_release_with_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (&ss_n));
    // R5: an unusable divider keeps the engine idle.
    assert_slow_div_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !div_ok) |=> !busy);
    // R4: sclk moves only on a divider tick while shifting.
    assert_sclk_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !tick) |=> $stable(sclk));
endmodule

// File: tb/spi_shift_engine_bench.sv
// Sweeping bench: TX FIFO and RX FIFO models plus a behavioural SPI slave.
module spi_shift_engine_bench;
    localparam int DW = 16, DIV_W = 16, FRM_W = 16, NUM_SS = 4, SEL_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [9:0]        cfg_ctrl = '0;
    logic [FRM_W-1:0]  cfg_rx_frames = '0;
    logic [DIV_W-1:0]  cfg_div = 16'd2;
    logic [SEL_W-1:0]  cfg_target = '0;
    logic              tx_empty, tx_pop, rx_full = 1'b0, rx_push;
    logic [DW-1:0]     tx_data, rx_data;
    logic              sclk, mosi, miso, busy;
    logic [NUM_SS-1:0] ss_n;

    always #10 clk = ~clk;

    spi_shift_engine u_spi_shift_engine (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_rx_frames(cfg_rx_frames),
        .cfg_div(cfg_div), .cfg_target(cfg_target), .tx_empty(tx_empty), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .busy(busy)
    );

    int errors = 0, checks = 0;
    int run_id = 0;

    task automatic chk(input bit ok, input string req, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] txw(input int r, input int i);
        return 16'(32'h3C69 + r * 32'h0F1E + i * 32'h1357);
    endfunction
    function automatic logic [15:0] swd(input int r, input int i);
        return 16'(32'hA5C3 ^ (r * 32'h0B57) ^ (i * 32'h2461));
    endfunction
    function automatic logic [15:0] nmask(input int n);
        return 16'((32'h1 << n) - 1);
    endfunction

    // TX FIFO model (fall-through) and RX FIFO sink.
    logic [15:0] tx_mem [0:1023];
    logic [15:0] rx_mem [0:1023];
    int tx_cnt = 0, tx_rd = 0, rx_wr = 0;
    assign tx_empty = (tx_rd == tx_cnt);
    assign tx_data  = tx_mem[tx_rd[9:0]];
    always @(posedge clk) begin
        if (tx_pop) tx_rd <= tx_rd + 1;
        if (rx_push) begin
            rx_mem[rx_wr[9:0]] <= rx_data;
            rx_wr <= rx_wr + 1;
        end
    end

    // Behavioural slave: samples mosi and drives miso by edge count.
    int b_n = 8, b_cpol = 0, b_cpha = 0;
    int e = 0, bits = 0, fr_idx = 0, leads = 0, ss_falls = 0, mo_cnt = 0;
    logic [15:0] mo_sh = '0;
    logic [15:0] mo_mem [0:1023];
    logic mosi_d = 1'b0, prev_sclk = 1'b0, act_prev = 1'b0;
    time t_edge = 0, t_l1 = 0, t_l2 = 0, t_rel = 0;

    always @(negedge clk) mosi_d = mosi;

    function automatic logic slave_bit(input int ee, input int fi, input int pha, input int n, input int r);
        int k;
        logic [15:0] w;
        k = pha ? (ee + 1) / 2 - 1 : (ee + 1) / 2;
        if (k < 0) k = 0;
        if (k > n - 1) k = n - 1;
        w = swd(r, fi);
        return w[n - 1 - k];
    endfunction
    assign miso = slave_bit(e, fr_idx, b_cpha, b_n, run_id);

    always @(sclk or ss_n) begin
        logic act, lead;
        act = (ss_n != '1);
        if (act && !act_prev) begin
            ss_falls++; e = 0; bits = 0; fr_idx = 0; leads = 0; mo_sh = '0;
        end
        if (!act && act_prev) t_rel = $time - t_edge;
        if (act && act_prev && sclk !== prev_sclk) begin
            t_edge = $time;
            lead = (sclk != b_cpol[0]);
            if (lead) begin
                leads++;
                if (leads == 1) t_l1 = $time;
                if (leads == 2) t_l2 = $time;
            end
            e++;
            if (b_cpha[0] ? !lead : lead) begin
                mo_sh = {mo_sh[14:0], mosi_d};
                bits++;
                if (bits == b_n) begin
                    mo_mem[mo_cnt[9:0]] = mo_sh;
                    mo_cnt++; bits = 0; mo_sh = '0;
                end
            end
            if (e == 2 * b_n) begin
                e = 0; fr_idx++;
            end
        end
        prev_sclk = sclk;
        act_prev = act;
    end

    // One burst with full checking.
    task automatic run_case(input int mode, input int pol, input int pha, input int fszm1,
                            input int div, input int frf, input bit full, input int tgt);
        int nfr, mo_base, rx_base, fall_base, d_eff, h, expect_rx, wait_n;
        logic [15:0] m;
        @(negedge clk);
        run_id++;
        b_n = fszm1 + 1; b_cpol = pol; b_cpha = pha;
        m = nmask(b_n);
        cfg_ctrl = {2'(mode), 1'(pol), 1'(pha), 2'(frf), 4'(fszm1)};
        cfg_div = 16'(div);
        cfg_target = 2'(tgt);
        cfg_rx_frames = 16'd2;
        rx_full = full;
        nfr = 3;
        d_eff = (div / 2) * 2;
        h = div / 2;
        mo_base = mo_cnt; rx_base = rx_wr; fall_base = ss_falls;
        @(negedge clk);
        if (mode == 2) begin
            tx_mem[tx_cnt[9:0]] = 16'hFFFF; tx_cnt++;
        end else begin
            for (int i = 0; i < nfr; i++) begin
                tx_mem[tx_cnt[9:0]] = txw(run_id, i); tx_cnt++;
            end
        end
        wait_n = 0;
        while (!busy && wait_n < 20) begin @(negedge clk); wait_n++; end
        chk(busy, "R6 start", longint'(busy), 1);
        chk(ss_n == ~(4'b1 << tgt), "R6 one-hot select", longint'(ss_n), longint'(~(4'b1 << tgt) & 4'hF));
        wait_n = 0;
        while (busy && wait_n < 20000) begin @(negedge clk); wait_n++; end
        repeat (2) @(negedge clk);
        rx_full = 1'b0;
        // R2, R9: frames seen by the slave.
        chk(mo_cnt - mo_base == nfr, "R2 frame count", longint'(mo_cnt - mo_base), longint'(nfr));
        for (int i = 0; i < nfr; i++) begin
            logic [15:0] ex;
            ex = (mode == 2) ? 16'h0 : (txw(run_id, i) & m);
            chk(mo_mem[(mo_base + i) % 1024] == ex, (mode == 2) ? "R9 zero out" : "R2 mosi word",
                longint'(mo_mem[(mo_base + i) % 1024]), longint'(ex));
        end
        // R3, R8, R10: what came back.
        expect_rx = (mode == 1 || full) ? 0 : nfr;
        chk(rx_wr - rx_base == expect_rx, (mode == 1) ? "R8 no push" : (full ? "R10 full drop" : "R9 push count"),
            longint'(rx_wr - rx_base), longint'(expect_rx));
        for (int i = 0; i < expect_rx && i < rx_wr - rx_base; i++) begin
            logic [15:0] ex;
            ex = swd(run_id, i) & m;
            chk(rx_mem[(rx_base + i) % 1024] == ex, "R3 rx word", longint'(rx_mem[(rx_base + i) % 1024]), longint'(ex));
        end
        chk(ss_falls - fall_base == 1, "R6 single select fall", longint'(ss_falls - fall_base), 1);
        chk(t_rel == time'(h * 20), "R7 release delay", longint'(t_rel), longint'(h * 20));
        chk(t_l2 - t_l1 == time'(d_eff * 20), "R4 sclk period", longint'(t_l2 - t_l1), longint'(d_eff * 20));
        chk(sclk == pol[0], "R3 idle polarity", longint'(sclk), longint'(pol));
        chk(tx_empty && ss_n == '1, "R7 drained and released", longint'({tx_empty, ss_n}), 5'h1F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state.
        chk(!busy && !tx_pop && !rx_push && ss_n == '1 && sclk == 1'b0, "R11 reset state",
            longint'({busy, tx_pop, rx_push, ss_n, sclk}), 8'h1E);
        // R1, R2, R3, R8, R9: sweep direction, clock mode, frame length, divider.
        for (int mode = 0; mode < 4; mode++)
            for (int cm = 0; cm < 4; cm++)
                for (int fz = 0; fz < 3; fz++)
                    for (int dv = 0; dv < 2; dv++)
                        run_case(mode, cm / 2, cm % 2, (fz == 0) ? 3 : ((fz == 1) ? 7 : 15),
                                 (dv == 0) ? 2 : 6, (mode + cm + fz) % 4, 1'b0, (cm + fz) % 4);
        // R4: odd divider behaves as the even value below it.
        run_case(0, 1, 0, 7, 7, 0, 1'b0, 3);
        run_case(0, 0, 1, 11, 9, 2, 1'b0, 1);
        // R10: full receive FIFO drops frames.
        run_case(0, 0, 0, 7, 4, 0, 1'b1, 2);
        run_case(2, 1, 1, 7, 2, 0, 1'b1, 0);
        // R5: divider of 1 starts nothing.
        begin
            int rd0;
            @(negedge clk);
            cfg_div = 16'd1;
            cfg_ctrl = 10'h007;
            rd0 = tx_rd;
            tx_mem[tx_cnt[9:0]] = 16'h1234; tx_cnt++;
            repeat (30) @(negedge clk);
            chk(!busy && tx_rd == rd0 && ss_n == '1, "R5 div 1 blocked",
                longint'({busy, 4'(tx_rd - rd0), ss_n}), 9'h00F);
            cfg_div = 16'd0;
            repeat (10) @(negedge clk);
            chk(!busy && tx_rd == rd0, "R5 div 0 blocked", longint'(tx_rd - rd0), 0);
            cfg_div = 16'd4;
            repeat (200) @(negedge clk);
            chk(tx_empty && !busy, "R5 resumes with valid divider", longint'({tx_empty, busy}), 2'b10);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule